// File: doc/BRIEF.md
# Slot-Table Weighted Priority Scheduler

This block chooses which traffic class an output queue sends next. A class is picked only at a packet boundary. A boundary is the moment a new class becomes available while the block is idle, or the strobe that marks the current packet as finished. A table of sixteen slots, each naming one of four classes, is read through a pointer. When the named class has a packet waiting, that class is chosen. When it has none, the most urgent class that has a packet is chosen instead. Class 0 is the most urgent and class 3 the least.

Each finished packet moves the pointer one slot forward, with a wrap after the last slot. The pointer moves even when the fallback class was the one served. As a result, every class is guaranteed roughly the share of slots that the table gives it, and no slot goes unused while any class has work.

The controller has two named states. ST_IDLE means no class is selected. ST_SERVE means a selection is being held. The transitions are:
- start: ST_IDLE to ST_SERVE, taken when any class becomes non-empty.
- next: ST_SERVE to ST_SERVE, taken on a finished packet while work remains.
- drain: ST_SERVE to ST_IDLE, taken on a finished packet when every class is empty.
- wait: the block stays in its current state when neither of the above occurs.

The slot table is rewritten through a one-beat write port. A write is first seen by the next boundary decision.

Top module: `slot_prio_sched`

## Requirements
- R1: After reset, sel_valid is 0, sel_prio is 0, the pointer is at slot 0, and slot i holds class i mod 4.
- R2: In ST_IDLE, a cycle with any bit of q_nonempty set makes sel_valid 1 on the following cycle, with the decision taken from the slot under the pointer.
- R3: At a boundary, if the q_nonempty bit of the class named by the read slot is set, sel_prio becomes that class.
- R4: At a boundary, if the named class is empty, sel_prio becomes the lowest-numbered class whose q_nonempty bit is set (class 0 is most urgent).
- R5: While sel_valid is 1 and pkt_done is 0, sel_prio and sel_valid keep their values whatever q_nonempty does.
- R6: pkt_done while sel_valid is 1 advances the pointer by one, from slot 15 to slot 0, whether the named or the fallback class was served. The decision made on that cycle reads the advanced slot.
- R7: pkt_done while sel_valid is 1 and all q_nonempty bits are 0 makes sel_valid 0 and sel_prio 0 on the next cycle.
- R8: cfg_we writes cfg_prio into slot cfg_addr. A decision made in the same cycle as the write still reads the slot's old value, and later decisions read the new one.
- R9: pkt_done while sel_valid is 0 is ignored and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_nonempty | input | 4 | One bit per class, set when that class has a packet waiting |
| pkt_done | input | 1 | One-cycle strobe: the selected packet has been fully sent |
| cfg_we | input | 1 | Slot table write enable |
| cfg_addr | input | 4 | Slot index to write |
| cfg_prio | input | 2 | Class number to store in the slot |
| sel_valid | output | 1 | A class is selected |
| sel_prio | output | 2 | Selected class, 0 when sel_valid is 0 |

## Verification
Every decision is registered once. A boundary seen on the q_nonempty or pkt_done values present at a rising edge therefore shows up on sel_valid and sel_prio right after that edge. A table write lands at the same edge and is first used at the boundary after it. The bench drives inputs on the falling edge and keeps a reference model of the pointer, the table and the selection. At each rising edge it applies the decision first and the table write second, then compares the outputs at the next falling edge. This means every comparison falls exactly one register stage after its stimulus and never on an edge.

// File: rtl/slotsched_pkg.sv
package slotsched_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } sched_state_e;

endpackage

// File: rtl/slot_table.sv
module slot_table #(
    parameter int DEPTH = 16,
    parameter int NPRIO = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(NPRIO)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [PW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [PW-1:0] rd_data
);

    logic [PW-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= PW'(i % NPRIO);
            end else if (wr_en && (wr_addr == AW'(i))) begin
                mem_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R8: a write lands in the addressed slot at the next edge
    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (int'(wr_addr) < DEPTH) |=> mem_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/slot_pointer.sv
module slot_pointer #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] ptr_q,
    output logic [AW-1:0] ptr_next
);

    always_comb begin
        ptr_next = (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= ptr_next;
        end
    end

    // R6: an advance moves by exactly one slot, wrapping after the last
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ((ptr_q == $past(ptr_q) + AW'(1)) || (ptr_q == '0 && $past(ptr_q) == LAST)));

    // R9: without an advance the pointer holds
    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr_q));

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int NPRIO = 4,
    localparam int PW = $clog2(NPRIO)
) (
    input  logic [NPRIO-1:0] nonempty,
    input  logic [PW-1:0]    slot_prio,
    output logic [PW-1:0]    pick,
    output logic             any
);

    logic [PW-1:0] urgent;

    // Lowest-numbered non-empty class; scanning downward lets class 0 win
    always_comb begin
        urgent = '0;
        for (int k = NPRIO - 1; k >= 0; k--) begin
            if (nonempty[k]) urgent = PW'(k);
        end
    end

    always_comb begin
        any  = |nonempty;
        pick = nonempty[slot_prio] ? slot_prio : urgent;
    end

    // R4: whenever some class has work, the chosen class has work
    always_comb begin
        if (any) begin
            assert_pick_nonempty_R4: assert (nonempty[pick]);
        end
    end

endmodule

// File: rtl/slot_prio_sched.sv
module slot_prio_sched #(
    parameter int DEPTH = 16,
    parameter int NPRIO = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(NPRIO)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPRIO-1:0] q_nonempty,
    input  logic             pkt_done,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [PW-1:0]    cfg_prio,
    output logic             sel_valid,
    output logic [PW-1:0]    sel_prio
);

    import slotsched_pkg::*;

    sched_state_e  state_q, state_d;
    logic [PW-1:0] sel_q;
    logic          load;
    logic          adv;
    logic [AW-1:0] ptr_q, ptr_next, rd_addr;
    logic [PW-1:0] slot_prio, pick;
    logic          any;

    slot_pointer #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .ptr_q    (ptr_q),
        .ptr_next (ptr_next)
    );

    slot_table #(.DEPTH(DEPTH), .NPRIO(NPRIO)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_prio),
        .rd_addr (rd_addr),
        .rd_data (slot_prio)
    );

    prio_pick #(.NPRIO(NPRIO)) u_pick (
        .nonempty  (q_nonempty),
        .slot_prio (slot_prio),
        .pick      (pick),
        .any       (any)
    );

    // Boundary and next-state logic
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        adv     = 1'b0;
        rd_addr = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any) begin
                    load    = 1'b1;
                    state_d = ST_SERVE;
                end
            end
            ST_SERVE: begin
                if (pkt_done) begin
                    adv     = 1'b1;
                    rd_addr = ptr_next;
                    if (any) begin
                        load = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) sel_q <= pick;
        end
    end

    // Outputs
    always_comb begin
        sel_valid = (state_q == ST_SERVE);
        sel_prio  = sel_valid ? sel_q : '0;
    end

    // R2: a selection only appears after some class had work
    assert_start_needs_work_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_valid) |-> $past(|q_nonempty));

    // R5: the selection holds between boundaries
    assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid && !pkt_done |=> sel_valid && $stable(sel_prio));

    // R7: a finished packet with no work left empties the selection
    assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid && pkt_done && !(|q_nonempty) |=> !sel_valid && sel_prio == '0);

    // R1: an idle block reports class 0
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> sel_prio == '0);

endmodule

// File: tb/slot_prio_sched_bench.sv
`timescale 1ns/1ps
module slot_prio_sched_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] q_nonempty = '0;
    logic       pkt_done = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [1:0] cfg_prio = '0;
    logic       sel_valid;
    logic [1:0] sel_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [1:0] m_tbl [16];
    int         m_ptr;
    bit         m_valid;
    logic [1:0] m_sel;

    always #2 clk = ~clk;

    slot_prio_sched u_slot_prio_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_nonempty (q_nonempty),
        .pkt_done   (pkt_done),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_prio   (cfg_prio),
        .sel_valid  (sel_valid),
        .sel_prio   (sel_prio)
    );

    function automatic logic [1:0] decide(logic [1:0] slot, logic [3:0] ne);
        if (ne[slot]) return slot;
        for (int k = 0; k < 4; k++) if (ne[k]) return 2'(k);
        return 2'd0;
    endfunction

    task automatic check(string req);
        logic [1:0] exp_p;
        exp_p = m_valid ? m_sel : 2'd0;
        checks++;
        if (sel_valid !== m_valid || sel_prio !== exp_p) begin
            fails++;
            $display("FAIL %s: valid=%0b prio=%0d expected valid=%0b prio=%0d",
                     req, sel_valid, sel_prio, m_valid, exp_p);
        end
    endtask

    // inputs already driven; model the edge, then compare at the falling edge
    task automatic step(string req);
        if (!m_valid) begin
            if (|q_nonempty) begin
                m_sel   = decide(m_tbl[m_ptr], q_nonempty);
                m_valid = 1'b1;
            end
        end else if (pkt_done) begin
            m_ptr = (m_ptr + 1) % 16;
            if (|q_nonempty) m_sel = decide(m_tbl[m_ptr], q_nonempty);
            else             m_valid = 1'b0;
        end
        if (cfg_we) m_tbl[cfg_addr] = cfg_prio;
        @(posedge clk);
        @(negedge clk);
        check(req);
    endtask

    task automatic drive(logic [3:0] ne, logic d);
        q_nonempty = ne;
        pkt_done   = d;
        cfg_we     = 1'b0;
    endtask

    initial begin
        int r;
        for (int i = 0; i < 16; i++) m_tbl[i] = 2'(i % 4);
        m_ptr = 0; m_valid = 1'b0; m_sel = '0;
        r = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2 R3: start from idle, slot 0 names class 0
        drive(4'b1111, 1'b0); step("R2");
        drive(4'b1111, 1'b0); step("R5");
        // R3 R6: walk through the default table with every class busy
        for (int i = 0; i < 18; i++) begin
            drive(4'b1111, 1'b1); step("R6");
        end
        // R4: only class 0 has work; named slots fall back to it
        for (int i = 0; i < 3; i++) begin
            drive(4'b0001, 1'b1); step("R4");
        end
        // R5: flags change without a boundary
        drive(4'b1000, 1'b0); step("R5");
        drive(4'b0110, 1'b0); step("R5");
        // R7: drain when nothing is left
        drive(4'b0000, 1'b1); step("R7");
        // R9: strobes while idle are ignored
        drive(4'b0000, 1'b1); step("R9");
        drive(4'b0000, 1'b1); step("R9");
        drive(4'b1111, 1'b0); step("R9");
        // R8: write the next slot on the same edge as the boundary
        q_nonempty = 4'b1111; pkt_done = 1'b1;
        cfg_we = 1'b1; cfg_addr = 4'((m_ptr + 1) % 16); cfg_prio = 2'd3;
        step("R8");
        // a second write, then wrap the table around to reach it
        q_nonempty = 4'b1111; pkt_done = 1'b0;
        cfg_we = 1'b1; cfg_addr = 4'((m_ptr + 1) % 16); cfg_prio = 2'd2;
        step("R8");
        drive(4'b1111, 1'b1); step("R8");
        for (int i = 0; i < 16; i++) begin
            drive(4'b1101, 1'b1); step("R3");
        end

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            r = $urandom;
            q_nonempty = ((r & 32'h70) == 0) ? 4'b0000 : 4'(r);
            pkt_done   = ((r >> 8) % 3) == 0;
            cfg_we     = ((r >> 12) % 8) == 0;
            cfg_addr   = 4'(r >> 16);
            cfg_prio   = 2'(r >> 20);
            step(cfg_we ? "R8" : (pkt_done ? "R6" : "R5"));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule